// File: doc/BRIEF.md
# Register Steering Target Lookup

This block decides, for one register address, whether an access to a replicated register must first be steered to a particular copy, and if so which group and instance to select. It keeps eight programmable steering classes. Each class has an ordered list of inclusive address windows and one programmed group/instance target. A separate "implicit" list holds windows whose registers are already steered by a setting made once, so a hit there means no steering is needed. An address that no list covers is given the safe guess of group 0, instance 0 with steering on, and a warning flag is raised so the issuing agent can log the miss.

Lookups are registered. The address is presented with a valid strobe, and the answer appears one clock later. Window lists and targets are loaded through simple write ports. A window whose end is zero closes its list, so an unloaded class contributes nothing. A second, independent path converts a sub-slice index into a group/instance pair by dividing by a configurable sub-slices-per-group count. Until that count is written, it takes a default chosen by a platform-generation parameter.

Top module: `steer_target_lookup`

## Requirements
- R1: `res_valid` is high exactly in the cycle after a cycle with `lk_valid` high, and low otherwise; the result fields hold the answer for the address presented with that strobe.
- R2: Window bounds are inclusive: an address equal to a window's start or end hits it, while start-1 and end+1 do not (absent other windows).
- R3: Within a list, an entry whose end is zero terminates the list; it and all entries after it never match until it is loaded with a non-zero end. A class with entry 0 unloaded is skipped.
- R4: Classes are searched in fixed priority, class 0 highest; when several classes cover the address, the lowest-numbered class supplies `res_group`/`res_inst`, with `res_steer`=1 and `res_unknown`=0.
- R5: The implicit list (selected by `rng_sel` = 8) is consulted only when no class matches; an implicit hit gives `res_steer`=0, `res_unknown`=0, group 0, instance 0.
- R6: An address matching no class and no implicit window gives `res_steer`=1, group 0, instance 0 and `res_unknown`=1.
- R7: A window or target write takes effect for lookups presented in later cycles; a lookup presented in the same cycle as a write sees the contents from before the write.
- R8: A sub-slice request `dss_idx`=d with `dss_valid` gives, one cycle later with `dss_res_valid`=1, `dss_group` = d / N and `dss_inst` = d mod N, where N is the current sub-slices-per-group count.
- R9: After reset, N is 8 when `PLAT_GEN`=0, 4 when 1 and 6 when 2, until `dpg_we` writes a new count.
- R10: Writing a count of 0 through `dpg_we` sets N to 1.
- R11: Reset clears every window, every target and both result valids; after reset any lookup reports `res_unknown`=1.
- R12: `tgt_we` loads `tgt_group`/`tgt_inst` as the target of class `tgt_sel`, used by later hits on that class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rng_we | input | 1 | Window write strobe |
| rng_sel | input | 4 | List to write: 0..7 class, 8 implicit |
| rng_idx | input | 4 | Entry index within the list |
| rng_start | input | 24 | Window start address (inclusive) |
| rng_end | input | 24 | Window end address (inclusive); 0 closes the list |
| tgt_we | input | 1 | Target write strobe |
| tgt_sel | input | 3 | Class whose target is written |
| tgt_group | input | 4 | Group target value |
| tgt_inst | input | 4 | Instance target value |
| dpg_we | input | 1 | Sub-slices-per-group write strobe |
| dpg_val | input | 4 | New count (0 treated as 1) |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | 24 | Register address to look up |
| res_valid | output | 1 | Lookup result valid |
| res_steer | output | 1 | Steering required |
| res_group | output | 4 | Group to steer to |
| res_inst | output | 4 | Instance to steer to |
| res_unknown | output | 1 | Address found in no list |
| dss_valid | input | 1 | Sub-slice mapping request |
| dss_idx | input | 7 | Sub-slice index |
| dss_res_valid | output | 1 | Mapping result valid |
| dss_group | output | 7 | Group of the sub-slice |
| dss_inst | output | 7 | Instance of the sub-slice |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a table write and a lookup. The bench issues a window write and a lookup of an address inside that new window on the same clock edge, expects the pre-write answer (unknown), and then expects the hit on the following lookup. The second pair is an address lookup and a sub-slice mapping issued together, including right after a count change. The scoreboard holds a separate expected queue for each result stream, so each answer is judged against the model state at issue time.

// File: rtl/steer_pkg.sv
// Package: shared definitions for the steering target lookup.
// Holds the platform-generation encoding and the default
// sub-slices-per-group count derived from it.
package steer_pkg;

    // Platform generation selector used for the default divisor.
    typedef enum int {
        GEN_WIDE   = 0,
        GEN_MID    = 1,
        GEN_LEGACY = 2
    } plat_gen_e;

    // Default sub-slices-per-group count per generation.
    function automatic int unsigned default_dss_per_group(int unsigned gen);
        case (gen)
            0:       return 8;
            1:       return 4;
            default: return 6;
        endcase
    endfunction

endpackage

// File: rtl/steer_range_table.sv
// Module: one ordered list of inclusive address windows.
// Stores DEPTH start/end pairs written one at a time and reports
// whether an address falls inside any live window. A window is live
// only if it and every earlier entry have a non-zero end, so the
// first zero end closes the list.
// Assumes DEPTH >= 2 and that the write index port can address it.
module steer_range_table #(
    parameter int DEPTH  = 12,
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [ADDR_W-1:0] wstart,
    input  logic [ADDR_W-1:0] wend,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int LIDX = $clog2(DEPTH);

    logic [ADDR_W-1:0] start_q [DEPTH];
    logic [ADDR_W-1:0] end_q   [DEPTH];
    logic [DEPTH-1:0]  match;

    // Window storage: cleared on reset, one entry written per strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                start_q[i] <= '0;
                end_q[i]   <= '0;
            end
        end else if (we && (32'(widx) < DEPTH)) begin
            start_q[widx[LIDX-1:0]] <= wstart;
            end_q[widx[LIDX-1:0]]   <= wend;
        end
    end

    // Per-entry inclusive compare, gated by the running list-open flag.
    always_comb begin
        logic alive;
        alive = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            alive    = alive && (end_q[i] != '0);
            match[i] = alive && (addr >= start_q[i]) && (addr <= end_q[i]);
        end
    end

    // Any live window containing the address.
    assign hit = |match;

    // R3: an unloaded first entry closes the list, so nothing can hit.
    p_empty_list_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (end_q[0] == '0) |-> !hit);

endmodule

// File: rtl/steer_prio_select.sv
// Module: fixed-priority merge of per-class hits.
// Class 0 has the highest priority. If no class hits, an implicit
// hit turns steering off; otherwise the fallback 0/0 target is used
// with the unknown flag set. Purely combinational; clock and reset
// feed only the embedded checks.
module steer_prio_select #(
    parameter int NUM_TYPES = 8,
    parameter int GRP_W     = 4,
    parameter int INST_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_TYPES-1:0] type_hit,
    input  logic                 impl_hit,
    input  logic [GRP_W-1:0]     grp_tab  [NUM_TYPES],
    input  logic [INST_W-1:0]    inst_tab [NUM_TYPES],
    output logic                 steer,
    output logic [GRP_W-1:0]     grp,
    output logic [INST_W-1:0]    inst,
    output logic                 unknown
);
    logic [NUM_TYPES-1:0] win;

    // Pick the lowest-numbered hitting class as a one-hot winner.
    always_comb begin
        logic found;
        found = 1'b0;
        win   = '0;
        for (int t = 0; t < NUM_TYPES; t++) begin
            if (type_hit[t] && !found) begin
                win[t] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // Form the answer from the winner, the implicit list or the fallback.
    always_comb begin
        steer   = 1'b1;
        grp     = '0;
        inst    = '0;
        unknown = 1'b0;
        if (|win) begin
            for (int t = 0; t < NUM_TYPES; t++) begin
                if (win[t]) begin
                    grp  = grp_tab[t];
                    inst = inst_tab[t];
                end
            end
        end else if (impl_hit) begin
            steer = 1'b0;
        end else begin
            unknown = 1'b1;
        end
    end

    // R4: at most one class wins.
    p_single_winner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win));

    // R5: any class hit masks the implicit list.
    p_class_masks_impl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|type_hit) |-> (steer && !unknown));

endmodule

// File: rtl/steer_dss_map.sv
// Module: sub-slice index to group/instance mapping.
// Holds the sub-slices-per-group count (default from PLAT_GEN, a
// written zero becomes one) and registers quotient and remainder one
// cycle after a request. A request in the same cycle as a count write
// uses the old count.
module steer_dss_map #(
    parameter int DSS_W    = 7,
    parameter int DPG_W    = 4,
    parameter int PLAT_GEN = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [DPG_W-1:0] cfg_val,
    input  logic             req_valid,
    input  logic [DSS_W-1:0] req_idx,
    output logic             res_valid,
    output logic [DSS_W-1:0] res_group,
    output logic [DSS_W-1:0] res_inst
);
    import steer_pkg::*;

    localparam logic [DPG_W-1:0] DEF_N = DPG_W'(default_dss_per_group(PLAT_GEN));

    logic [DPG_W-1:0] n_q;
    logic [DSS_W-1:0] n_ext;

    // Divisor register: default after reset, zero writes clamp to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_q <= DEF_N;
        end else if (cfg_we) begin
            n_q <= (cfg_val == '0) ? DPG_W'(1) : cfg_val;
        end
    end

    assign n_ext = DSS_W'(n_q);

    // Result register: quotient is the group, remainder the instance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_group <= '0;
            res_inst  <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_group <= req_idx / n_ext;
                res_inst  <= req_idx % n_ext;
            end
        end
    end

    // R10: the divisor is never zero.
    p_divisor_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        n_q != '0);

    // R8: the instance stays below the count it was computed with.
    p_inst_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_inst < DSS_W'($past(n_q))));

endmodule

// File: rtl/steer_target_lookup.sv
// Module: top of the steering target lookup.
// Instantiates one window list per steering class plus the implicit
// list, the class target registers, the priority merge and the
// sub-slice mapper. Lookups are registered: the answer is valid the
// cycle after the request. Writes take effect from the next cycle.
// Assumes RANGES_PER_TYPE >= IMPL_RANGES and both are >= 2.
module steer_target_lookup #(
    parameter int NUM_TYPES       = 8,
    parameter int RANGES_PER_TYPE = 12,
    parameter int IMPL_RANGES     = 8,
    parameter int ADDR_W          = 24,
    parameter int GRP_W           = 4,
    parameter int INST_W          = 4,
    parameter int DSS_W           = 7,
    parameter int DPG_W           = 4,
    parameter int PLAT_GEN        = 0,
    localparam int SEL_W  = $clog2(NUM_TYPES + 1),
    localparam int TSEL_W = $clog2(NUM_TYPES),
    localparam int IDX_W  = $clog2(RANGES_PER_TYPE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rng_we,
    input  logic [SEL_W-1:0]  rng_sel,
    input  logic [IDX_W-1:0]  rng_idx,
    input  logic [ADDR_W-1:0] rng_start,
    input  logic [ADDR_W-1:0] rng_end,
    input  logic              tgt_we,
    input  logic [TSEL_W-1:0] tgt_sel,
    input  logic [GRP_W-1:0]  tgt_group,
    input  logic [INST_W-1:0] tgt_inst,
    input  logic              dpg_we,
    input  logic [DPG_W-1:0]  dpg_val,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              res_valid,
    output logic              res_steer,
    output logic [GRP_W-1:0]  res_group,
    output logic [INST_W-1:0] res_inst,
    output logic              res_unknown,
    input  logic              dss_valid,
    input  logic [DSS_W-1:0]  dss_idx,
    output logic              dss_res_valid,
    output logic [DSS_W-1:0]  dss_group,
    output logic [DSS_W-1:0]  dss_inst
);
    logic [NUM_TYPES-1:0] type_hit;
    logic                 impl_hit;
    logic [GRP_W-1:0]     grp_q  [NUM_TYPES];
    logic [INST_W-1:0]    inst_q [NUM_TYPES];
    logic                 sel_steer;
    logic [GRP_W-1:0]     sel_grp;
    logic [INST_W-1:0]    sel_inst;
    logic                 sel_unknown;

    // One window list per steering class.
    for (genvar t = 0; t < NUM_TYPES; t++) begin : g_class
        steer_range_table #(
            .DEPTH  (RANGES_PER_TYPE),
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W)
        ) u_tab (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (rng_we && (rng_sel == SEL_W'(t))),
            .widx   (rng_idx),
            .wstart (rng_start),
            .wend   (rng_end),
            .addr   (lk_addr),
            .hit    (type_hit[t])
        );
    end

    // Implicit list: selected by the select code just past the classes.
    steer_range_table #(
        .DEPTH  (IMPL_RANGES),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_impl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rng_we && (rng_sel == SEL_W'(NUM_TYPES))),
        .widx   (rng_idx),
        .wstart (rng_start),
        .wend   (rng_end),
        .addr   (lk_addr),
        .hit    (impl_hit)
    );

    // Class target registers: cleared on reset, loaded by the target port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_TYPES; t++) begin
                grp_q[t]  <= '0;
                inst_q[t] <= '0;
            end
        end else if (tgt_we) begin
            grp_q[tgt_sel]  <= tgt_group;
            inst_q[tgt_sel] <= tgt_inst;
        end
    end

    steer_prio_select #(
        .NUM_TYPES (NUM_TYPES),
        .GRP_W     (GRP_W),
        .INST_W    (INST_W)
    ) u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .type_hit (type_hit),
        .impl_hit (impl_hit),
        .grp_tab  (grp_q),
        .inst_tab (inst_q),
        .steer    (sel_steer),
        .grp      (sel_grp),
        .inst     (sel_inst),
        .unknown  (sel_unknown)
    );

    // Result register: capture the merged answer on each request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_steer   <= 1'b0;
            res_group   <= '0;
            res_inst    <= '0;
            res_unknown <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_steer   <= sel_steer;
                res_group   <= sel_grp;
                res_inst    <= sel_inst;
                res_unknown <= sel_unknown;
            end
        end
    end

    steer_dss_map #(
        .DSS_W    (DSS_W),
        .DPG_W    (DPG_W),
        .PLAT_GEN (PLAT_GEN)
    ) u_dss (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (dpg_we),
        .cfg_val   (dpg_val),
        .req_valid (dss_valid),
        .req_idx   (dss_idx),
        .res_valid (dss_res_valid),
        .res_group (dss_group),
        .res_inst  (dss_inst)
    );

    // R1: a request yields a result in the next cycle.
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R1: no request, no result.
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R6: the fallback is always the 0/0 target with steering on.
    p_fallback_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_unknown) |-> (res_steer && res_group == '0 && res_inst == '0));

    // R5: a no-steer answer is never flagged unknown and carries no target.
    p_implicit_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_steer) |-> (!res_unknown && res_group == '0 && res_inst == '0));

endmodule

// File: tb/tb_steer_target_lookup.sv
// Scoreboard bench: driver tasks push expected answers, computed from
// a bench-side model of the programmed lists, into queues; a monitor
// on the falling edge pops and compares each result as it appears.
module tb_steer_target_lookup;
    localparam int NT = 8;
    localparam int NR = 12;
    localparam int NI = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rng_we = 1'b0;
    logic [3:0]  rng_sel = '0;
    logic [3:0]  rng_idx = '0;
    logic [23:0] rng_start = '0;
    logic [23:0] rng_end = '0;
    logic        tgt_we = 1'b0;
    logic [2:0]  tgt_sel = '0;
    logic [3:0]  tgt_group = '0;
    logic [3:0]  tgt_inst = '0;
    logic        dpg_we = 1'b0;
    logic [3:0]  dpg_val = '0;
    logic        lk_valid = 1'b0;
    logic [23:0] lk_addr = '0;
    logic        res_valid, res_steer, res_unknown;
    logic [3:0]  res_group, res_inst;
    logic        dss_valid = 1'b0;
    logic [6:0]  dss_idx = '0;
    logic        dss_res_valid;
    logic [6:0]  dss_group, dss_inst;

    steer_target_lookup dut (
        .clk(clk), .rst_n(rst_n),
        .rng_we(rng_we), .rng_sel(rng_sel), .rng_idx(rng_idx),
        .rng_start(rng_start), .rng_end(rng_end),
        .tgt_we(tgt_we), .tgt_sel(tgt_sel), .tgt_group(tgt_group), .tgt_inst(tgt_inst),
        .dpg_we(dpg_we), .dpg_val(dpg_val),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .res_valid(res_valid), .res_steer(res_steer), .res_group(res_group),
        .res_inst(res_inst), .res_unknown(res_unknown),
        .dss_valid(dss_valid), .dss_idx(dss_idx),
        .dss_res_valid(dss_res_valid), .dss_group(dss_group), .dss_inst(dss_inst)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Bench model of the programmed state.
    logic [23:0] m_s [0:NT][0:15];
    logic [23:0] m_e [0:NT][0:15];
    logic [3:0]  m_g [0:NT-1];
    logic [3:0]  m_i [0:NT-1];
    int          m_n = 8;

    // Expected queues: lookup {steer, group, inst, unknown}, sub-slice {group, inst}.
    logic [9:0]  q_lk [$];
    string       q_lk_tag [$];
    logic [13:0] q_ds [$];
    string       q_ds_tag [$];

    function automatic logic list_hit(int l, int depth, logic [23:0] a);
        for (int i = 0; i < depth; i++) begin
            if (m_e[l][i] == 24'd0) return 1'b0;
            if (a >= m_s[l][i] && a <= m_e[l][i]) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic [9:0] model_lookup(logic [23:0] a);
        for (int t = 0; t < NT; t++)
            if (list_hit(t, NR, a)) return {1'b1, m_g[t], m_i[t], 1'b0};
        if (list_hit(NT, NI, a)) return {1'b0, 4'd0, 4'd0, 1'b0};
        return {1'b1, 4'd0, 4'd0, 1'b1};
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare every result with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (q_lk.size() == 0) check("R1 unexpected lookup result", 32'd1, 32'd0);
            else check(q_lk_tag.pop_front(), {22'd0, res_steer, res_group, res_inst, res_unknown},
                       {22'd0, q_lk.pop_front()});
        end
        if (rst_n && dss_res_valid) begin
            if (q_ds.size() == 0) check("R8 unexpected sub-slice result", 32'd1, 32'd0);
            else check(q_ds_tag.pop_front(), {18'd0, dss_group, dss_inst}, {18'd0, q_ds.pop_front()});
        end
    end

    task automatic wr_rng(int sel, int idx, logic [23:0] s, logic [23:0] e);
        @(negedge clk);
        rng_we = 1'b1; rng_sel = 4'(sel); rng_idx = 4'(idx); rng_start = s; rng_end = e;
        m_s[sel][idx] = s; m_e[sel][idx] = e;
        @(negedge clk);
        rng_we = 1'b0;
    endtask

    task automatic wr_tgt(int sel, logic [3:0] g, logic [3:0] i);
        @(negedge clk);
        tgt_we = 1'b1; tgt_sel = 3'(sel); tgt_group = g; tgt_inst = i;
        m_g[sel] = g; m_i[sel] = i;
        @(negedge clk);
        tgt_we = 1'b0;
    endtask

    task automatic wr_dpg(logic [3:0] v);
        @(negedge clk);
        dpg_we = 1'b1; dpg_val = v;
        m_n = (v == 4'd0) ? 1 : int'(v);
        @(negedge clk);
        dpg_we = 1'b0;
    endtask

    task automatic push_lk(string tag, logic [23:0] a);
        q_lk.push_back(model_lookup(a));
        q_lk_tag.push_back(tag);
    endtask

    task automatic push_ds(string tag, int d);
        q_ds.push_back({7'(d / m_n), 7'(d % m_n)});
        q_ds_tag.push_back(tag);
    endtask

    task automatic lookup(string tag, logic [23:0] a);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        push_lk(tag, a);
        @(negedge clk);
        lk_valid = 1'b0;
    endtask

    task automatic dss(string tag, int d);
        @(negedge clk);
        dss_valid = 1'b1; dss_idx = 7'(d);
        push_ds(tag, d);
        @(negedge clk);
        dss_valid = 1'b0;
    endtask

    // Lookup and sub-slice mapping in the same cycle.
    task automatic both(string tag, logic [23:0] a, int d);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; dss_valid = 1'b1; dss_idx = 7'(d);
        push_lk(tag, a);
        push_ds(tag, d);
        @(negedge clk);
        lk_valid = 1'b0; dss_valid = 1'b0;
    endtask

    // Window write and lookup in the same cycle: expected uses pre-write model.
    task automatic collide(string tag, int sel, int idx, logic [23:0] s, logic [23:0] e,
                           logic [23:0] a);
        @(negedge clk);
        push_lk(tag, a);
        rng_we = 1'b1; rng_sel = 4'(sel); rng_idx = 4'(idx); rng_start = s; rng_end = e;
        lk_valid = 1'b1; lk_addr = a;
        m_s[sel][idx] = s; m_e[sel][idx] = e;
        @(negedge clk);
        rng_we = 1'b0; lk_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int l = 0; l <= NT; l++)
            for (int i = 0; i < 16; i++) begin
                m_s[l][i] = '0; m_e[l][i] = '0;
            end
        for (int t = 0; t < NT; t++) begin
            m_g[t] = '0; m_i[t] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 res_valid after reset", {31'd0, res_valid}, 32'd0);
        check("R11 dss_res_valid after reset", {31'd0, dss_res_valid}, 32'd0);

        lookup("R11 empty lists give unknown", 24'h001234);
        dss("R9 default count 8", 19);

        wr_rng(2, 0, 24'h00B100, 24'h00B3FF);
        wr_tgt(2, 4'd5, 4'd1);
        wr_rng(5, 0, 24'h00DE80, 24'h00E8FF);
        wr_tgt(5, 4'd3, 4'd7);
        lookup("R2 start bound hits", 24'h00B100);
        lookup("R2 end bound hits", 24'h00B3FF);
        lookup("R2 below start misses", 24'h00B0FF);
        lookup("R6 above end falls back", 24'h00B400);
        lookup("R12 class 5 target", 24'h00E000);

        wr_rng(6, 0, 24'h00B200, 24'h00B2FF);
        wr_tgt(6, 4'd9, 4'd9);
        lookup("R4 class 2 beats class 6", 24'h00B250);
        wr_rng(1, 0, 24'h00B280, 24'h00B290);
        wr_tgt(1, 4'd1, 4'd2);
        lookup("R4 class 1 beats class 2", 24'h00B285);

        wr_rng(3, 0, 24'h001000, 24'h0010FF);
        wr_rng(3, 2, 24'h002000, 24'h0020FF);
        wr_tgt(3, 4'd4, 4'd4);
        lookup("R3 entry after terminator ignored", 24'h002050);
        lookup("R3 entry before terminator hits", 24'h001050);
        wr_rng(3, 1, 24'h003000, 24'h0030FF);
        lookup("R3 filled gap opens later entry", 24'h002050);

        wr_rng(8, 0, 24'h004000, 24'h0040FF);
        lookup("R5 implicit hit no steering", 24'h004010);
        wr_rng(8, 1, 24'h00B100, 24'h00B1FF);
        lookup("R5 class hit masks implicit", 24'h00B150);

        wr_tgt(7, 4'd2, 4'd6);
        collide("R7 lookup sees pre-write list", 7, 0, 24'h005000, 24'h0050FF, 24'h005010);
        lookup("R7 write visible next cycle", 24'h005010);

        wr_tgt(2, 4'd12, 4'd3);
        lookup("R12 updated class 2 target", 24'h00B300);

        wr_dpg(4'd4);
        dss("R8 count 4", 13);
        wr_dpg(4'd6);
        dss("R8 count 6 top index", 127);
        wr_dpg(4'd0);
        dss("R10 zero count acts as one", 45);
        both("R1 R8 lookup with mapping", 24'h00E8FF, 100);
        wr_dpg(4'd5);
        both("R7 R8 lookup with mapping after count change", 24'h004000, 23);

        repeat (3) @(negedge clk);
        check("R1 lookup queue drained", 32'(q_lk.size()), 32'd0);
        check("R8 mapping queue drained", 32'(q_ds.size()), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule